// File: doc/BRIEF.md
# I2S Slave Stereo Input Receiver

This block receives stereo audio on a serial bus in I2S format as a pure slave. An external master owns the bit clock (`sck`) and the word-select line (`ws`), and the block never drives either. Any number of data lines (`sd`, two by default) share that one bit clock and word select. Each line is deserialised into a left sample and a right sample at a fixed internal precision of `SAMPLE_W` bits (20 by default). A serial word of any length is accepted. Bits past the internal precision are discarded, and a word that is too short has its missing low-order positions filled with zeros. All lanes are captured on the same edges, so their samples stay aligned.

When a right word ends, the block latches the complete stereo pair of every lane in the bit-clock domain and flips a toggle. A synchroniser passes that toggle into the core clock domain (`clk`). There a single-cycle pulse loads an output register that presents the pair on a valid/ready stream. Back-pressure rules: `out_valid` stays high and `out_left`/`out_right` stay stable until a cycle with `out_ready` high. If a new pair arrives while the held pair has not yet been accepted, the new pair is dropped and the held pair is kept. No pair is buffered beyond the output register.

The core clock must run fast enough that the synchroniser settles well within one serial word, several times the bit-clock rate. This holds easily for stereo word rates of 32, 44.1 and 48 kHz. The serial timing has no relation to any output-side timing of the chip.

Top module: `i2s_rx_stereo`

## Requirements
- R1: After reset `out_valid` is low. No pair is presented until one complete left word and then one complete right word have been received after the first `ws` transition seen after reset.
- R2: `sd` and `ws` are sampled on the rising edge of `sck`. `ws` low (0) marks a left word and high (1) marks a right word. A word's MSB is the bit sampled one bit-clock after the edge at which `ws` is first seen changed. The word ends with the bit sampled at the edge where the next `ws` change is first seen.
- R3: When a word carries more than `SAMPLE_W` bits, its first `SAMPLE_W` bits (MSB first) form the sample and all later bits are ignored.
- R4: When a word carries fewer than `SAMPLE_W` bits, its bits fill the sample from the MSB down and the remaining low-order bits are zero.
- R5: Lane `i` (data line `sd[i]`) appears at `out_left[i*SAMPLE_W +: SAMPLE_W]` and `out_right[i*SAMPLE_W +: SAMPLE_W]`. All lanes are captured on the same bit-clock edges.
- R6: A pair is offered at the end of each right word that follows a captured left word. `out_valid` rises no later than the fourth core-clock rising edge after the bit-clock edge that closes the right word.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_left` and `out_right` hold. After a cycle with both high, `out_valid` drops unless a new pair loads in that cycle.
- R8: A pair that arrives while `out_valid` is high and `out_ready` is low is dropped, and the held pair is unchanged.
- R9: The end of a left word alone produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sck | input | 1 | Serial bit clock from the external master |
| ws | input | 1 | Word select from the master, 0 = left, 1 = right |
| sd | input | LANES | Serial data lines, one per lane |
| out_ready | input | 1 | Downstream accepts the presented pair |
| out_valid | output | 1 | A stereo pair is presented |
| out_left | output | LANES*SAMPLE_W | Left samples, lane 0 in the low bits |
| out_right | output | LANES*SAMPLE_W | Right samples, lane 0 in the low bits |

## Verification
The serial deserialisation has no fixed cycle relation to the core clock. The pair becomes due a bounded number of core cycles after the bit-clock edge that closes the right word: two synchroniser flops plus the output register. The bench therefore waits for that closing edge and then samples `out_valid` on falling core-clock edges for a short window. It counts how many samples pass before the pair shows and requires that count to be at most four. The window ends before the next falling bit-clock edge, so no stimulus overlaps it. The checks of the held pair (R7, R8) and of silence after a left word (R9) use the same window, and the acceptance check samples one core cycle after the pair is seen.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s_rx_frame.sv
// Word framing in the bit-clock domain: word-select edge detection, bit
// counter with saturation, and the left-then-right pairing state.
module i2s_rx_frame #(
  parameter  int unsigned SAMPLE_W = 20,
  localparam int unsigned CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic               sck,
  input  logic               rst_n,
  input  logic               ws,
  output i2s_rx_pkg::chan_e  word_chan,
  output logic               ws_edge,
  output logic               take_bit,
  output logic [CNT_W-1:0]   bit_idx,
  output logic               word_end,
  output logic               pair_fire
);
  import i2s_rx_pkg::*;

  logic             ws_q;
  logic             started;
  logic             left_seen;
  logic [CNT_W-1:0] cnt;

  // The word in progress belongs to the channel seen on the previous edge.
  assign word_chan = chan_e'(ws_q);
  assign ws_edge   = ws ^ ws_q;
  assign take_bit  = (cnt < CNT_W'(SAMPLE_W));
  assign bit_idx   = cnt;
  assign word_end  = ws_edge && started;
  assign pair_fire = word_end && (word_chan == CH_RIGHT) && left_seen;

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      ws_q      <= 1'b0;
      started   <= 1'b0;
      left_seen <= 1'b0;
      cnt       <= '0;
    end else begin
      ws_q <= ws;
      if (ws_edge) begin
        cnt     <= '0;
        started <= 1'b1;
        if (word_end && (word_chan == CH_LEFT)) left_seen <= 1'b1;
      end else if (take_bit) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2s_rx_lane.sv
// One data line: MSB-first accumulation with zero fill and truncation.
module i2s_rx_lane #(
  parameter int unsigned SAMPLE_W = 20,
  parameter int unsigned CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                    sck,
  input  logic                    rst_n,
  input  logic                    sd,
  input  i2s_rx_pkg::chan_e       word_chan,
  input  logic                    ws_edge,
  input  logic                    take_bit,
  input  logic [CNT_W-1:0]        bit_idx,
  input  logic                    word_end,
  output logic [SAMPLE_W-1:0]     left_word,
  output logic [SAMPLE_W-1:0]     cur_word
);
  import i2s_rx_pkg::*;

  logic [SAMPLE_W-1:0] acc;

  // Current word including the bit on the line at this edge.
  always_comb begin
    cur_word = acc;
    for (int b = 0; b < SAMPLE_W; b++) begin
      if (take_bit && (bit_idx == CNT_W'(SAMPLE_W - 1 - b))) cur_word[b] = sd;
    end
  end

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      left_word <= '0;
    end else begin
      acc <= ws_edge ? '0 : cur_word;
      if (word_end && (word_chan == CH_LEFT)) left_word <= cur_word;
    end
  end
endmodule

// File: rtl/i2s_rx_cdc.sv
// Toggle handshake: data held in the source domain, toggle synchronised
// into the destination domain, one-cycle pulse on each toggle change.
module i2s_rx_cdc #(
  parameter int unsigned DATA_W      = 80,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              rst_n,
  input  logic              src_load,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_tgl,
  input  logic              dst_clk,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_pulse
);
  logic [DATA_W-1:0]      hold;
  logic [SYNC_STAGES-1:0] sync;
  logic                   last_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      src_tgl <= 1'b0;
    end else if (src_load) begin
      hold    <= src_data;
      src_tgl <= ~src_tgl;
    end
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= '0;
      last_q <= 1'b0;
    end else begin
      sync   <= {sync[SYNC_STAGES-2:0], src_tgl};
      last_q <= sync[SYNC_STAGES-1];
    end
  end

  assign dst_pulse = sync[SYNC_STAGES-1] ^ last_q;
  // Held data is stable for a whole serial word after each toggle.
  assign dst_data  = hold;
endmodule

// File: rtl/i2s_rx_stereo.sv
module i2s_rx_stereo #(
  parameter int unsigned LANES       = 2,
  parameter int unsigned SAMPLE_W    = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sck,
  input  logic                      ws,
  input  logic [LANES-1:0]          sd,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [LANES*SAMPLE_W-1:0] out_left,
  output logic [LANES*SAMPLE_W-1:0] out_right
);
  localparam int unsigned CNT_W  = $clog2(SAMPLE_W + 1);
  localparam int unsigned BUS_W  = LANES * SAMPLE_W;
  localparam int unsigned PAIR_W = 2 * BUS_W;

  i2s_rx_pkg::chan_e word_chan;
  logic              ws_edge;
  logic              take_bit;
  logic [CNT_W-1:0]  bit_idx;
  logic              word_end;
  logic              pair_fire;
  logic [BUS_W-1:0]  left_bus;
  logic [BUS_W-1:0]  right_bus;
  logic              pair_tgl;
  logic              pair_pulse;
  logic [PAIR_W-1:0] pair_data;

  i2s_rx_frame #(.SAMPLE_W(SAMPLE_W)) u_frame (
    .sck       (sck),
    .rst_n     (rst_n),
    .ws        (ws),
    .word_chan (word_chan),
    .ws_edge   (ws_edge),
    .take_bit  (take_bit),
    .bit_idx   (bit_idx),
    .word_end  (word_end),
    .pair_fire (pair_fire)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    i2s_rx_lane #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_lane (
      .sck       (sck),
      .rst_n     (rst_n),
      .sd        (sd[i]),
      .word_chan (word_chan),
      .ws_edge   (ws_edge),
      .take_bit  (take_bit),
      .bit_idx   (bit_idx),
      .word_end  (word_end),
      .left_word (left_bus[i*SAMPLE_W +: SAMPLE_W]),
      .cur_word  (right_bus[i*SAMPLE_W +: SAMPLE_W])
    );
  end

  i2s_rx_cdc #(.DATA_W(PAIR_W), .SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .src_clk   (sck),
    .rst_n     (rst_n),
    .src_load  (pair_fire),
    .src_data  ({right_bus, left_bus}),
    .src_tgl   (pair_tgl),
    .dst_clk   (clk),
    .dst_data  (pair_data),
    .dst_pulse (pair_pulse)
  );

  // Output stage: load when empty or being emptied; otherwise drop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (pair_pulse && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_left  <= pair_data[BUS_W-1:0];
      out_right <= pair_data[PAIR_W-1:BUS_W];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_rx_stereo_chk.sv
module i2s_rx_stereo_chk #(
  parameter int unsigned LANES    = 2,
  parameter int unsigned SAMPLE_W = 20
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sck,
  input logic                      ws_q,
  input logic                      pair_tgl,
  input logic                      pair_pulse,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [LANES*SAMPLE_W-1:0] out_left,
  input logic [LANES*SAMPLE_W-1:0] out_right
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !pair_pulse) |=> !out_valid);

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_pulse && !out_valid) |=> out_valid);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_pulse |=> !pair_pulse);

  assert_pair_on_right_end_R2: assert property (@(posedge sck) disable iff (!rst_n)
    !$stable(pair_tgl) |-> ($past(ws_q) == 1'b1 && ws_q == 1'b0));
endmodule

bind i2s_rx_stereo i2s_rx_stereo_chk #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck        (sck),
  .ws_q       (word_chan),
  .pair_tgl   (pair_tgl),
  .pair_pulse (pair_pulse),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_left   (out_left),
  .out_right  (out_right)
);

// File: tb/i2s_rx_stereo_tb.sv
`timescale 1ns/1ps
module i2s_rx_stereo_tb;
  localparam int LANES = 2;
  localparam int W     = 20;

  logic                clk = 1'b0;
  logic                sck = 1'b0;
  logic                rst_n = 1'b0;
  logic                ws = 1'b1;
  logic [LANES-1:0]    sd = '0;
  logic                out_ready = 1'b1;
  logic                out_valid;
  logic [LANES*W-1:0]  out_left;
  logic [LANES*W-1:0]  out_right;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_l [LANES];
  logic [W-1:0] exp_r [LANES];
  logic [W-1:0] hold_l [LANES];
  logic [W-1:0] hold_r [LANES];

  i2s_rx_stereo #(.LANES(LANES), .SAMPLE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  always #2.5 clk = ~clk;
  initial begin
    #13;
    forever #40 sck = ~sck;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_val(int n, int seed, int lane, int ch);
    logic [63:0] x;
    x = 64'(seed + 1) * 64'h9E3779B97F4A7C15;
    x = x ^ (64'(lane * 7 + ch * 13 + n) * 64'hC2B2AE3D27D4EB4F);
    x = x ^ (x >> 29);
    if (n >= 32) return x[31:0];
    return x[31:0] & ((32'h1 << n) - 32'h1);
  endfunction

  // R3 / R4: expected 20-bit sample from an n-bit serial word.
  function automatic logic [W-1:0] exp20(logic [31:0] v, int n);
    if (n >= W) return W'(v >> (n - W));
    return W'(v << (W - n));
  endfunction

  // One word, MSB first; ws moves to the next channel during the LSB slot.
  task automatic send_word(input bit ch, input int n, input logic [31:0] a0,
                           input logic [31:0] a1);
    for (int j = n - 1; j >= 0; j--) begin
      @(negedge sck);
      sd[0] = a0[j];
      sd[1] = a1[j];
      ws    = (j == 0) ? ~ch : ch;
    end
  endtask

  task automatic send_pair(input int n, input int seed);
    logic [31:0] l0, l1, r0, r1;
    int seen;
    l0 = word_val(n, seed, 0, 0); l1 = word_val(n, seed, 1, 0);
    r0 = word_val(n, seed, 0, 1); r1 = word_val(n, seed, 1, 1);
    exp_l[0] = exp20(l0, n); exp_l[1] = exp20(l1, n);
    exp_r[0] = exp20(r0, n); exp_r[1] = exp20(r1, n);
    send_word(1'b0, n, l0, l1);
    @(posedge sck);
    if (out_ready) begin
      seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (out_valid) seen++;
      end
      check(seen == 0, "R9 no output after left word", 64'(seen), 64'd0);
    end
    send_word(1'b1, n, r0, r1);
    @(posedge sck);
  endtask

  function automatic string data_tag(int n);
    if (n > W) return "R3 long word";
    if (n < W) return "R4 short word";
    return "R2 exact word";
  endfunction

  // Called right after the closing bit-clock edge of a right word.
  task automatic await_pair(input int n);
    int found;
    logic [LANES*W-1:0] got_l, got_r;
    found = -1;
    got_l = '0; got_r = '0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (out_valid && found < 0) begin
        found = k; got_l = out_left; got_r = out_right;
      end
    end
    check(found >= 0 && found <= 4, "R6 pair latency", 64'(found), 64'd4);
    for (int i = 0; i < LANES; i++) begin
      check(got_l[i*W +: W] == exp_l[i],
            (i == 0) ? {data_tag(n), " left lane0"} : {data_tag(n), " R5 left lane1"},
            64'(got_l[i*W +: W]), 64'(exp_l[i]));
      check(got_r[i*W +: W] == exp_r[i],
            (i == 0) ? {data_tag(n), " right lane0"} : {data_tag(n), " R5 right lane1"},
            64'(got_r[i*W +: W]), 64'(exp_r[i]));
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    int seen;
    int lens [9] = '{8, 12, 16, 19, 20, 21, 24, 28, 32};
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset state", 64'(out_valid), 64'd0);

    // R1: arming right word after reset yields nothing.
    send_word(1'b1, 8, 32'hA5, 32'h5A);
    @(posedge sck);
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    check(seen == 0, "R1 no output before left+right", 64'(seen), 64'd0);

    // Sweep word lengths and patterns with the sink always ready.
    for (int li = 0; li < 9; li++) begin
      for (int s = 0; s < 3; s++) begin
        send_pair(lens[li], s + li * 3);
        await_pair(lens[li]);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 valid drops after accept", 64'(out_valid), 64'd0);
      end
    end

    // R7 / R8: back-pressure, second pair dropped.
    out_ready = 1'b0;
    send_pair(24, 100);
    await_pair(24);
    for (int i = 0; i < LANES; i++) begin
      hold_l[i] = exp_l[i];
      hold_r[i] = exp_r[i];
    end
    send_pair(24, 101);
    repeat (5) @(negedge clk);
    check(out_valid == 1'b1, "R7 valid held while not ready", 64'(out_valid), 64'd1);
    for (int i = 0; i < LANES; i++) begin
      check(out_left[i*W +: W] == hold_l[i], "R8 held left kept",
            64'(out_left[i*W +: W]), 64'(hold_l[i]));
      check(out_right[i*W +: W] == hold_r[i], "R8 held right kept",
            64'(out_right[i*W +: W]), 64'(hold_r[i]));
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 valid drops after late accept", 64'(out_valid), 64'd0);

    // Traffic resumes normally afterwards.
    send_pair(20, 102);
    await_pair(20);
    send_pair(32, 103);
    await_pair(32);

    finish_run();
  end
endmodule